// File: doc/BRIEF.md
# Parallel camera capture front end

This block sits right behind the pins of an 8-bit parallel image sensor. It takes a vertical sync, a horizontal reference and a data byte on every pixel clock, and it turns that stream into per-pixel luma and chroma samples. The block runs in the pixel clock domain (`clk`). It can sample the sensor pins on either edge of that clock, and it can invert the vertical sync and the horizontal reference on their own. It splits the interleaved 4:2:2 bytes in one of four byte orders. It keeps only the pixels inside a programmable crop window and marks the first pixel of a frame and the last pixel of each cropped line. An internal pattern source can replace the sensor bytes while the sensor's own sync timing is kept.

Configuration is held on static inputs:
- `cfg_src_size`: width in pixels in the upper half, line count in the lower half.
- `cfg_lead_ofs`: left margin upper, top margin lower.
- `cfg_trail_ofs`: right margin upper, bottom margin lower.

Cropping applies only when the left or the top margin is nonzero. A host works out the trailing margins as width minus crop width minus left, and height minus crop height minus top.

A three-state machine follows the sensor timing:
- **IDLE**: left after any reset. Nothing is captured here.
- **BLANK**: frame active, between lines.
- **LINE**: reference active.

The transitions are:
- *frame start* (active edge of vertical sync): from any state to BLANK. It also clears the line count.
- *line begin*: BLANK to LINE when the reference goes active.
- *line end*: LINE to BLANK when the reference goes inactive. It advances the line count.

Top module: `camfe_top`

## Requirements
- R1: After `rst_n` low, or in the cycle after `soft_rst` is high, `pix_vld`, `pix_sof` and `pix_eol` are 0. Capture stays stopped until the next active vertical sync edge, so any rest of an interrupted frame yields no samples.
- R2: With cropping off, only pixels with column < width and line < height (from `cfg_src_size`: width bits 31:16, height bits 15:0) are emitted. Extra pixels or lines driven by the sensor are dropped.
- R3: With left (`cfg_lead_ofs` 31:16) or top (15:0) nonzero, only pixels with left ≤ column < width − right and top ≤ line < height − bottom are emitted. Right is `cfg_trail_ofs` 31:16 and bottom is 15:0.
- R4: With left and top both zero, the trailing margins have no effect and the full source frame is emitted.
- R5: `cfg_order` selects the byte order in a pixel pair: 0 = Y,Cb,Y,Cr; 1 = Y,Cr,Y,Cb; 2 = Cb,Y,Cr,Y; 3 = Cr,Y,Cb,Y. Each pixel gives `pix_y` and `pix_c`. Exactly one of `pix_cb_vld`/`pix_cr_vld` is set with `pix_vld`: Cb when column bit 0 equals `cfg_order` bit 0, else Cr.
- R6: `cfg_inv_vsync` and `cfg_inv_href` invert their pins. Normal polarity is active high for both, and the reference is high while line data flows.
- R7: With `cfg_inv_pclk` set, the pins are sampled on the falling clock edge instead of the rising edge.
- R8: The byte phase restarts at the first active byte of every line. A stray odd byte at the end of a line does not shift the decoding of the next line and yields no sample.
- R9: `pix_sof` marks the first emitted pixel after a frame start. `pix_eol` marks the emitted pixel whose column is the last column of the window.
- R10: `cfg_pattern` 0 passes sensor data. 1 gives bars: Y = ((column>>3)&7)<<5, Cb = ~Y, Cr = Y^8'h80. 2 gives Y = column[7:0]. 3 gives Y = line[7:0]. Patterns 2 and 3 give chroma 8'h80. All patterns follow the sensor sync timing.
- R11: Each active vertical sync edge restarts the line count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the sensor |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous capture reset |
| cam_vsync | input | 1 | Vertical sync pin |
| cam_href | input | 1 | Horizontal reference pin |
| cam_data | input | 8 | Sensor data byte |
| cfg_src_size | input | 32 | Source width (31:16) and height (15:0) |
| cfg_lead_ofs | input | 32 | Left (31:16) and top (15:0) margins |
| cfg_trail_ofs | input | 32 | Right (31:16) and bottom (15:0) margins |
| cfg_order | input | 2 | 4:2:2 byte order select |
| cfg_inv_pclk | input | 1 | Sample pins on falling edge |
| cfg_inv_vsync | input | 1 | Invert vertical sync |
| cfg_inv_href | input | 1 | Invert horizontal reference |
| cfg_pattern | input | 2 | Test pattern select |
| pix_vld | output | 1 | Pixel sample valid |
| pix_y | output | 8 | Luma sample |
| pix_c | output | 8 | Chroma sample |
| pix_cb_vld | output | 1 | Chroma is Cb |
| pix_cr_vld | output | 1 | Chroma is Cr |
| pix_sof | output | 1 | First pixel of frame |
| pix_eol | output | 1 | Last pixel of window line |

## Verification
The hardest case to reach from the ports is a line that ends on a half pixel. A well-behaved sensor never sends one, yet only such a line shows whether the byte phase really restarts at the next line. The bench drives a frame where every line carries one stray byte after its last pixel. It then checks that every following line decodes exactly as in a clean frame. Falling-edge sampling is reached in a similar way: the bench corrupts the data byte half a cycle after driving it, so only a falling-edge capture can see the good value.

// File: rtl/camfe_pkg.sv
package camfe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_LINE  = 2'd2
    } cap_state_e;

    localparam logic [1:0] PAT_OFF   = 2'd0;
    localparam logic [1:0] PAT_BARS  = 2'd1;
    localparam logic [1:0] PAT_HRAMP = 2'd2;
    localparam logic [1:0] PAT_VRAMP = 2'd3;
endpackage

// File: rtl/camfe_edge_sample.sv
module camfe_edge_sample #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inv_pclk,
    input  logic          inv_vs,
    input  logic          inv_hr,
    input  logic          vs_pin,
    input  logic          hr_pin,
    input  logic [DW-1:0] d_pin,
    output logic          vs_o,
    output logic          hr_o,
    output logic [DW-1:0] d_o
);
    localparam int BW = DW + 2;

    logic [BW-1:0] rise_q, fall_q, pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= {vs_pin, hr_pin, d_pin};
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= {vs_pin, hr_pin, d_pin};
    end

    always_comb begin
        pick = inv_pclk ? fall_q : rise_q;
        vs_o = pick[BW-1] ^ inv_vs;
        hr_o = pick[BW-2] ^ inv_hr;
        d_o  = pick[DW-1:0];
    end
endmodule

// File: rtl/camfe_pattern.sv
module camfe_pattern
    import camfe_pkg::*;
#(
    parameter int CW        = 16,
    parameter int DW        = 8,
    parameter int BAR_SHIFT = 3
) (
    input  logic [1:0]    sel,
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] row,
    input  logic          is_cb,
    output logic [DW-1:0] pat_y,
    output logic [DW-1:0] pat_c
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [2:0]    bar;
    logic [DW-1:0] bar_y;

    assign bar   = col[BAR_SHIFT +: 3];
    assign bar_y = {bar, {(DW-3){1'b0}}};

    always_comb begin
        unique case (sel)
            PAT_BARS: begin
                pat_y = bar_y;
                pat_c = is_cb ? ~bar_y : (bar_y ^ MID);
            end
            PAT_HRAMP: begin
                pat_y = col[DW-1:0];
                pat_c = MID;
            end
            PAT_VRAMP: begin
                pat_y = row[DW-1:0];
                pat_c = MID;
            end
            default: begin
                pat_y = '0;
                pat_c = '0;
            end
        endcase
    end
endmodule

// File: rtl/camfe_window.sv
module camfe_window #(
    parameter int CW = 16
) (
    input  logic [2*CW-1:0] src_size,
    input  logic [2*CW-1:0] lead_ofs,
    input  logic [2*CW-1:0] trail_ofs,
    input  logic [CW-1:0]   col,
    input  logic [CW-1:0]   row,
    output logic            in_win,
    output logic            last_col
);
    logic [CW-1:0] wid, hgt, lft, top, rgt, bot, xlo, ylo;
    logic [CW:0]   xend, yend;
    logic          crop_en;

    always_comb begin
        wid     = src_size[2*CW-1:CW];
        hgt     = src_size[CW-1:0];
        lft     = lead_ofs[2*CW-1:CW];
        top     = lead_ofs[CW-1:0];
        rgt     = trail_ofs[2*CW-1:CW];
        bot     = trail_ofs[CW-1:0];
        crop_en = (lft != '0) || (top != '0);
        xlo     = crop_en ? lft : '0;
        ylo     = crop_en ? top : '0;
        xend    = {1'b0, wid} - (crop_en ? {1'b0, rgt} : '0);
        yend    = {1'b0, hgt} - (crop_en ? {1'b0, bot} : '0);
        in_win  = !xend[CW] && !yend[CW]
                  && (col >= xlo) && ({1'b0, col} < xend)
                  && (row >= ylo) && ({1'b0, row} < yend);
        last_col = ({1'b0, col} + 1'b1) == xend;
    end
endmodule

// File: rtl/camfe_top.sv
module camfe_top
    import camfe_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cam_vsync,
    input  logic          cam_href,
    input  logic [7:0]    cam_data,
    input  logic [31:0]   cfg_src_size,
    input  logic [31:0]   cfg_lead_ofs,
    input  logic [31:0]   cfg_trail_ofs,
    input  logic [1:0]    cfg_order,
    input  logic          cfg_inv_pclk,
    input  logic          cfg_inv_vsync,
    input  logic          cfg_inv_href,
    input  logic [1:0]    cfg_pattern,
    output logic          pix_vld,
    output logic [7:0]    pix_y,
    output logic [7:0]    pix_c,
    output logic          pix_cb_vld,
    output logic          pix_cr_vld,
    output logic          pix_sof,
    output logic          pix_eol
);
    cap_state_e    state_q, state_d;
    logic          vs, hr, vs_prev_q, vs_edge;
    logic [DW-1:0] d, b0_q, pat_y, pat_c;
    logic          bph_q, phase, is_cb, in_win, last_col, sof_pend_q;
    logic [CW-1:0] x_q, y_q, xc;

    camfe_edge_sample #(.DW(DW)) u_sample (
        .clk(clk), .rst_n(rst_n), .inv_pclk(cfg_inv_pclk),
        .inv_vs(cfg_inv_vsync), .inv_hr(cfg_inv_href),
        .vs_pin(cam_vsync), .hr_pin(cam_href), .d_pin(cam_data),
        .vs_o(vs), .hr_o(hr), .d_o(d)
    );

    assign vs_edge = vs && !vs_prev_q;
    assign phase   = (state_q == ST_BLANK) ? 1'b0 : bph_q;
    assign xc      = (state_q == ST_BLANK) ? '0 : x_q;
    assign is_cb   = (xc[0] == cfg_order[0]);

    camfe_window #(.CW(CW)) u_window (
        .src_size(cfg_src_size[2*CW-1:0]), .lead_ofs(cfg_lead_ofs[2*CW-1:0]),
        .trail_ofs(cfg_trail_ofs[2*CW-1:0]), .col(xc), .row(y_q),
        .in_win(in_win), .last_col(last_col)
    );

    camfe_pattern #(.CW(CW), .DW(DW)) u_pattern (
        .sel(cfg_pattern), .col(xc), .row(y_q), .is_cb(is_cb),
        .pat_y(pat_y), .pat_c(pat_c)
    );

    always_comb begin
        state_d = state_q;
        if (vs_edge) begin
            state_d = ST_BLANK;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BLANK: state_d = hr ? ST_LINE : ST_BLANK;
                ST_LINE:  state_d = hr ? ST_LINE : ST_BLANK;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (soft_rst) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_prev_q <= 1'b0; sof_pend_q <= 1'b0; bph_q <= 1'b0;
            x_q <= '0; y_q <= '0; b0_q <= '0;
            pix_vld <= 1'b0; pix_y <= '0; pix_c <= '0;
            pix_cb_vld <= 1'b0; pix_cr_vld <= 1'b0;
            pix_sof <= 1'b0; pix_eol <= 1'b0;
        end else if (soft_rst) begin
            vs_prev_q <= 1'b0; sof_pend_q <= 1'b0; bph_q <= 1'b0;
            x_q <= '0; y_q <= '0; b0_q <= '0;
            pix_vld <= 1'b0; pix_y <= '0; pix_c <= '0;
            pix_cb_vld <= 1'b0; pix_cr_vld <= 1'b0;
            pix_sof <= 1'b0; pix_eol <= 1'b0;
        end else begin
            vs_prev_q  <= vs;
            pix_vld    <= 1'b0;
            pix_cb_vld <= 1'b0;
            pix_cr_vld <= 1'b0;
            pix_sof    <= 1'b0;
            pix_eol    <= 1'b0;
            if (vs_edge) begin
                y_q        <= '0;
                sof_pend_q <= 1'b1;
                bph_q      <= 1'b0;
            end else begin
                if (state_q == ST_LINE && !hr) y_q <= y_q + 1'b1;
                if (state_q != ST_IDLE && hr) begin
                    if (!phase) begin
                        b0_q  <= d;
                        bph_q <= 1'b1;
                        x_q   <= xc;
                    end else begin
                        bph_q <= 1'b0;
                        x_q   <= xc + 1'b1;
                        if (in_win) begin
                            pix_vld    <= 1'b1;
                            pix_cb_vld <= is_cb;
                            pix_cr_vld <= !is_cb;
                            pix_sof    <= sof_pend_q;
                            pix_eol    <= last_col;
                            sof_pend_q <= 1'b0;
                            if (cfg_pattern != PAT_OFF) begin
                                pix_y <= pat_y;
                                pix_c <= pat_c;
                            end else begin
                                pix_y <= cfg_order[1] ? d : b0_q;
                                pix_c <= cfg_order[1] ? b0_q : d;
                            end
                        end
                    end
                end
            end
        end
    end

    // R1
    soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!pix_vld && !pix_sof && !pix_eol));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !pix_vld);

    // R5
    chroma_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> ($countones({pix_cb_vld, pix_cr_vld}) == 1));

    // R5
    chroma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> !(pix_cb_vld || pix_cr_vld));

    // R9
    marker_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sof || pix_eol) |-> pix_vld);

    // R11
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        vs_edge |=> (state_q == ST_BLANK && y_q == '0));
endmodule

// File: tb/camfe_top_tb.sv
module camfe_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst = 1'b0;
    logic        cam_vsync = 1'b0, cam_href = 1'b0;
    logic [7:0]  cam_data = '0;
    logic [31:0] cfg_src_size = '0, cfg_lead_ofs = '0, cfg_trail_ofs = '0;
    logic [1:0]  cfg_order = '0, cfg_pattern = '0;
    logic        cfg_inv_pclk = 1'b0, cfg_inv_vsync = 1'b0, cfg_inv_href = 1'b0;
    logic        pix_vld, pix_cb_vld, pix_cr_vld, pix_sof, pix_eol;
    logic [7:0]  pix_y, pix_c;

    int n_chk = 0, n_err = 0;
    logic [19:0] exp_q[$];
    logic [19:0] act_q[$];

    always #4 clk = ~clk;

    camfe_top u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cam_vsync(cam_vsync), .cam_href(cam_href), .cam_data(cam_data),
        .cfg_src_size(cfg_src_size), .cfg_lead_ofs(cfg_lead_ofs),
        .cfg_trail_ofs(cfg_trail_ofs), .cfg_order(cfg_order),
        .cfg_inv_pclk(cfg_inv_pclk), .cfg_inv_vsync(cfg_inv_vsync),
        .cfg_inv_href(cfg_inv_href), .cfg_pattern(cfg_pattern),
        .pix_vld(pix_vld), .pix_y(pix_y), .pix_c(pix_c),
        .pix_cb_vld(pix_cb_vld), .pix_cr_vld(pix_cr_vld),
        .pix_sof(pix_sof), .pix_eol(pix_eol)
    );

    always @(negedge clk)
        if (pix_vld) act_q.push_back({pix_sof, pix_eol, pix_cb_vld, pix_cr_vld, pix_y, pix_c});

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        finish_run();
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sens_y(int x, int y);
        return 8'((x * 13 + y * 29 + 5) & 255);
    endfunction
    function automatic logic [7:0] sens_c(int x, int y);
        return 8'((x * 7 + y * 3 + 144) & 255);
    endfunction

    task automatic set_cfg(int w, int h, int l, int t, int r, int b, int ord, int pat);
        cfg_src_size  = {16'(w), 16'(h)};
        cfg_lead_ofs  = {16'(l), 16'(t)};
        cfg_trail_ofs = {16'(r), 16'(b)};
        cfg_order     = 2'(ord);
        cfg_pattern   = 2'(pat);
    endtask

    task automatic drive(bit vs, bit hr, logic [7:0] d, bit garb);
        @(posedge clk); #1;
        cam_vsync = vs ^ cfg_inv_vsync;
        cam_href  = hr ^ cfg_inv_href;
        cam_data  = d;
        if (garb) begin
            @(negedge clk); #1;
            cam_data = ~d;
        end
    endtask

    // Builds the expected sample list from the requirements, then drives the frame.
    task automatic send_frame(int wd, int hd, bit garb, bit stray, int soft_line);
        int w = int'(cfg_src_size[31:16]), h = int'(cfg_src_size[15:0]);
        int l = int'(cfg_lead_ofs[31:16]), t = int'(cfg_lead_ofs[15:0]);
        int r = int'(cfg_trail_ofs[31:16]), b = int'(cfg_trail_ofs[15:0]);
        bit en = (l != 0) || (t != 0);
        int xlo = en ? l : 0, ylo = en ? t : 0;
        int xend = en ? w - r : w, yend = en ? h - b : h;
        bit first = 1'b1;
        for (int y = 0; y < hd; y++) begin
            for (int x = 0; x < wd; x++) begin
                logic [7:0] ey, ec, by;
                bit cb;
                if (soft_line >= 0 && y > soft_line) continue;
                if (x < xlo || x >= xend || y < ylo || y >= yend || x >= w || y >= h) continue;
                cb = ((x & 1) == int'(cfg_order[0]));
                case (cfg_pattern)
                    2'd1: begin
                        by = 8'(((x >> 3) & 7) << 5);
                        ey = by;
                        ec = cb ? ~by : (by ^ 8'h80);
                    end
                    2'd2: begin ey = 8'(x); ec = 8'h80; end
                    2'd3: begin ey = 8'(y); ec = 8'h80; end
                    default: begin ey = sens_y(x, y); ec = sens_c(x, y); end
                endcase
                exp_q.push_back({first, (x == xend - 1), cb, !cb, ey, ec});
                first = 1'b0;
            end
        end
        for (int i = 0; i < 3; i++) drive(0, 0, 8'h00, 0);
        for (int i = 0; i < 2; i++) drive(1, 0, 8'h00, 0);
        for (int i = 0; i < 2; i++) drive(0, 0, 8'h00, 0);
        for (int y = 0; y < hd; y++) begin
            for (int x = 0; x < wd; x++) begin
                if (!cfg_order[1]) begin
                    drive(0, 1, sens_y(x, y), garb);
                    drive(0, 1, sens_c(x, y), garb);
                end else begin
                    drive(0, 1, sens_c(x, y), garb);
                    drive(0, 1, sens_y(x, y), garb);
                end
            end
            if (stray) drive(0, 1, 8'hEE, garb);
            for (int i = 0; i < 3; i++) drive(0, 0, 8'h00, 0);
            if (y == soft_line) begin
                @(posedge clk); #1 soft_rst = 1'b1;
                @(posedge clk); #1 soft_rst = 1'b0;
            end
        end
        for (int i = 0; i < 4; i++) drive(0, 0, 8'h00, 0);
    endtask

    task automatic compare(string tag);
        check({tag, " count"}, act_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
            check($sformatf("%s px%0d", tag, i), {12'd0, act_q[i]}, {12'd0, exp_q[i]});
        exp_q.delete();
        act_q.delete();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #4;
        check("R1 reset vld", {31'd0, pix_vld}, 0);
        check("R1 reset markers", {30'd0, pix_sof, pix_eol}, 0);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_full(); // R2 R4 R9 R11
        set_cfg(6, 3, 0, 0, 0, 0, 0, 0);
        send_frame(6, 3, 0, 0, -1);
        compare("R2 full frame");
        set_cfg(6, 3, 0, 0, 0, 0, 0, 0);
        send_frame(9, 5, 0, 0, -1);
        compare("R2 oversize sensor");
        set_cfg(8, 4, 0, 0, 3, 2, 0, 0);
        send_frame(8, 4, 0, 0, -1);
        compare("R4 trailing only");
    endtask

    task automatic t_crop(); // R3 R9
        set_cfg(10, 5, 2, 1, 3, 1, 0, 0);
        send_frame(10, 5, 0, 0, -1);
        compare("R3 crop both");
        set_cfg(8, 4, 1, 0, 0, 0, 0, 0);
        send_frame(8, 4, 0, 0, -1);
        compare("R3 crop left only");
    endtask

    task automatic t_orders(); // R5
        for (int o = 1; o < 4; o++) begin
            set_cfg(6, 2, 0, 0, 0, 0, o, 0);
            send_frame(6, 2, 0, 0, -1);
            compare($sformatf("R5 order %0d", o));
        end
    endtask

    task automatic t_polarity(); // R6
        cfg_inv_vsync = 1'b1; cfg_inv_href = 1'b1;
        drive(0, 0, 8'h00, 0);
        set_cfg(6, 3, 1, 1, 1, 0, 2, 0);
        send_frame(6, 3, 0, 0, -1);
        compare("R6 inverted syncs");
        cfg_inv_vsync = 1'b0; cfg_inv_href = 1'b0;
        drive(0, 0, 8'h00, 0);
    endtask

    task automatic t_fall(); // R7
        cfg_inv_pclk = 1'b1;
        set_cfg(6, 3, 0, 0, 0, 0, 1, 0);
        send_frame(6, 3, 1, 0, -1);
        compare("R7 falling edge");
        cfg_inv_pclk = 1'b0;
    endtask

    task automatic t_stray(); // R8
        set_cfg(6, 4, 0, 0, 0, 0, 3, 0);
        send_frame(6, 4, 0, 1, -1);
        compare("R8 stray byte");
    endtask

    task automatic t_pattern(); // R10
        for (int p = 1; p < 4; p++) begin
            set_cfg(20, 3, 0, 1, 0, 0, p - 1, p);
            send_frame(20, 3, 0, 0, -1);
            compare($sformatf("R10 pattern %0d", p));
        end
        cfg_pattern = 2'd0;
    endtask

    task automatic t_soft(); // R1 R11
        set_cfg(6, 4, 0, 0, 0, 0, 0, 0);
        send_frame(6, 4, 0, 0, 0);
        compare("R1 soft reset mid frame");
        send_frame(6, 4, 0, 0, -1);
        compare("R11 frame after soft reset");
    endtask

    initial begin
        t_reset();
        t_full();
        t_crop();
        t_orders();
        t_polarity();
        t_fall();
        t_stray();
        t_pattern();
        t_soft();
        finish_run();
    end
endmodule